// File: doc/BRIEF.md
# Accumulator ALU with carry flag

This block is an 8-bit arithmetic and logic unit that works on its own accumulator and carry flag. On each operation it takes a 4-bit operation code and an 8-bit operand. The operand already comes from a register, an immediate or memory, chosen outside the block. The block combines the operand with the stored accumulator and carry. It presents the next accumulator and carry values and one write enable for each of them, so that a surrounding datapath can see the results before they are committed.

When `op_valid` is high, the stored accumulator and carry take the new values at the rising clock edge. Each is written only when its own write enable is set. Carry is the only flag the block keeps. The block also reports a cycle cost for the operation, which depends on whether the operand was supplied in a register form or in an immediate or memory form.

Top module: `acc_alu8`

## Requirements
- R1: A synchronous active-high `rst` sets the stored accumulator and carry to zero at the next rising edge.
- R2: Code 0 (add) writes the low 8 bits of accumulator plus operand and sets carry exactly when that 9-bit sum is greater than 255.
- R3: Code 1 (add with carry) adds the stored carry bit to the accumulator and operand before the same overflow test as R2.
- R4: Code 2 (subtract) writes accumulator minus operand modulo 256 and sets carry when the true difference is below zero. Code 3 (subtract with borrow) also takes the stored carry away before that test.
- R5: Codes 4 (AND), 5 (XOR) and 6 (OR) write the bitwise result to the accumulator and always clear carry.
- R6: Code 7 (compare) leaves the accumulator as it was and sets carry to 1 exactly when the accumulator is unsigned-less-than the operand, and to 0 otherwise.
- R7: Code 8 (complement) inverts every accumulator bit and leaves carry as it was.
- R8: Code 9 toggles carry and code 10 sets carry to 1. Neither of them changes the accumulator.
- R9: Codes 11 (increment) and 12 (decrement) change the accumulator by one, wrapping modulo 256, and leave carry as it was.
- R10: `acc_we` is high for codes 0 to 6, 8, 11 and 12. `cy_we` is high for codes 0 to 7, 9 and 10. Codes 13 to 15 raise neither. When a write enable is low, the matching next-value output equals the stored value. Stored state changes only at an edge where `op_valid` is high.
- R11: `cost` is 8 for codes 0 to 7 when `opnd_ext` is high, and 4 in every other case.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Commit the operation at this edge |
| op_sel | input | 4 | Operation code |
| operand | input | 8 | Second operand |
| opnd_ext | input | 1 | Operand came from an immediate or memory |
| acc_q | output | 8 | Stored accumulator |
| cy_q | output | 1 | Stored carry |
| acc_nxt | output | 8 | Next accumulator value |
| cy_nxt | output | 1 | Next carry value |
| acc_we | output | 1 | Accumulator write enable |
| cy_we | output | 1 | Carry write enable |
| cost | output | 4 | Cycle cost of the operation |

## Verification
The next-value outputs, the write enables and `cost` are combinational. They are due in the same cycle the code and operand are applied, so the bench drives inputs on the falling edge and samples these outputs shortly afterwards, before the next rising edge. `acc_q` and `cy_q` change one rising edge later, and the bench samples them just after that edge and compares them with its own model, which it then advances. Steps with `op_valid` low are mixed into the random sequence, so the bench can confirm that the stored state holds across them.

// File: rtl/acc_alu8.sv
module acc_alu8 #(
  parameter int W  = 8,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic [3:0]    op_sel,
  input  logic [W-1:0]  operand,
  input  logic          opnd_ext,
  output logic [W-1:0]  acc_q,
  output logic          cy_q,
  output logic [W-1:0]  acc_nxt,
  output logic          cy_nxt,
  output logic          acc_we,
  output logic          cy_we,
  output logic [CW-1:0] cost
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADC = 4'd1, OP_SUB = 4'd2, OP_SBC = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4, OP_XOR = 4'd5, OP_OR  = 4'd6, OP_CMP = 4'd7;
  localparam logic [3:0] OP_CPL = 4'd8, OP_CCF = 4'd9, OP_SCF = 4'd10;
  localparam logic [3:0] OP_INC = 4'd11, OP_DEC = 4'd12;
  localparam logic [CW-1:0] COST_SHORT = CW'(4);
  localparam logic [CW-1:0] COST_LONG  = CW'(8);

  logic [W-1:0] add_b;
  logic         add_ci;
  logic         sub_like;
  logic [W:0]   sum;

  always_comb begin
    add_b    = operand;
    add_ci   = 1'b0;
    sub_like = 1'b0;
    case (op_sel)
      OP_ADC: add_ci = cy_q;
      OP_SUB, OP_CMP: begin add_b = ~operand; add_ci = 1'b1; sub_like = 1'b1; end
      OP_SBC: begin add_b = ~operand; add_ci = ~cy_q; sub_like = 1'b1; end
      OP_INC: begin add_b = '0; add_ci = 1'b1; end
      OP_DEC: begin add_b = '1; add_ci = 1'b0; end
      default: ;
    endcase
  end

  assign sum = {1'b0, acc_q} + {1'b0, add_b} + {{W{1'b0}}, add_ci};

  always_comb begin
    acc_nxt = acc_q;
    cy_nxt  = cy_q;
    acc_we  = 1'b0;
    cy_we   = 1'b0;
    case (op_sel)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC: begin
        acc_nxt = sum[W-1:0];
        cy_nxt  = sum[W] ^ sub_like;
        acc_we  = 1'b1;
        cy_we   = 1'b1;
      end
      OP_AND, OP_XOR, OP_OR: begin
        acc_nxt = (op_sel == OP_AND) ? (acc_q & operand) :
                  (op_sel == OP_XOR) ? (acc_q ^ operand) : (acc_q | operand);
        cy_nxt  = 1'b0;
        acc_we  = 1'b1;
        cy_we   = 1'b1;
      end
      OP_CMP: begin cy_nxt = ~sum[W]; cy_we = 1'b1; end
      OP_CPL: begin acc_nxt = ~acc_q; acc_we = 1'b1; end
      OP_CCF: begin cy_nxt = ~cy_q; cy_we = 1'b1; end
      OP_SCF: begin cy_nxt = 1'b1; cy_we = 1'b1; end
      OP_INC, OP_DEC: begin acc_nxt = sum[W-1:0]; acc_we = 1'b1; end
      default: ;
    endcase
  end

  assign cost = (opnd_ext && op_sel <= OP_CMP) ? COST_LONG : COST_SHORT;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      cy_q  <= 1'b0;
    end else if (op_valid) begin
      if (acc_we) acc_q <= acc_nxt;
      if (cy_we)  cy_q  <= cy_nxt;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && !cy_q));

  assert_logic_clears_carry_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_sel == OP_AND || op_sel == OP_XOR || op_sel == OP_OR)) |=> !cy_q);

  assert_cmp_keeps_acc_R6: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_CMP) |=> $stable(acc_q));

  assert_cpl_keeps_carry_R7: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_CPL) |=> ($stable(cy_q) && acc_q == ~$past(acc_q)));

  assert_scf_sets_R8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_SCF) |=> (cy_q && $stable(acc_q)));

  assert_incdec_keeps_carry_R9: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_sel == OP_INC || op_sel == OP_DEC)) |=> $stable(cy_q));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_sel > OP_DEC) |=> ($stable(acc_q) && $stable(cy_q)));

  assert_cost_range_R11: assert property (@(posedge clk) disable iff (rst)
    (cost == COST_SHORT || cost == COST_LONG));
endmodule

// File: tb/sim_acc_alu8.sv
module sim_acc_alu8;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, op_valid, opnd_ext;
  logic [3:0] op_sel;
  logic [7:0] operand;
  logic [7:0] acc_q, acc_nxt;
  logic       cy_q, cy_nxt, acc_we, cy_we;
  logic [3:0] cost;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0] m_acc;
  logic       m_cy;

  always #(CLK_PERIOD/2) clk = ~clk;

  acc_alu8 u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .operand(operand), .opnd_ext(opnd_ext), .acc_q(acc_q), .cy_q(cy_q),
    .acc_nxt(acc_nxt), .cy_nxt(cy_nxt), .acc_we(acc_we), .cy_we(cy_we), .cost(cost)
  );

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (op %0d)", tag, got, exp, op_sel);
    end
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R2";
      4'd1: return "R3";
      4'd2, 4'd3: return "R4";
      4'd4, 4'd5, 4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      4'd9, 4'd10: return "R8";
      4'd11, 4'd12: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic c, output logic [7:0] na, output logic nc,
                       output logic wa, output logic wc);
    int s;
    na = a; nc = c; wa = 0; wc = 0;
    case (op)
      4'd0, 4'd1: begin
        s = int'(a) + int'(b) + ((op == 4'd1) ? int'(c) : 0);
        na = s[7:0]; nc = (s > 255); wa = 1; wc = 1;
      end
      4'd2, 4'd3: begin
        s = int'(a) - int'(b) - ((op == 4'd3) ? int'(c) : 0);
        na = s[7:0]; nc = (s < 0); wa = 1; wc = 1;
      end
      4'd4: begin na = a & b; nc = 0; wa = 1; wc = 1; end
      4'd5: begin na = a ^ b; nc = 0; wa = 1; wc = 1; end
      4'd6: begin na = a | b; nc = 0; wa = 1; wc = 1; end
      4'd7: begin nc = (a < b); wc = 1; end
      4'd8: begin na = ~a; wa = 1; end
      4'd9: begin nc = ~c; wc = 1; end
      4'd10: begin nc = 1; wc = 1; end
      4'd11: begin na = a + 8'd1; wa = 1; end
      4'd12: begin na = a - 8'd1; wa = 1; end
      default: ;
    endcase
  endtask

  task automatic step(input logic v, input logic [3:0] op, input logic [7:0] b, input logic ext);
    logic [7:0] na;
    logic nc, wa, wc;
    string t;
    @(negedge clk);
    op_valid = v; op_sel = op; operand = b; opnd_ext = ext;
    #1;
    model(op, m_acc, m_cy, b, na, nc, wa, wc);
    model(op, m_acc, b, m_cy, na, nc, wa, wc);
    t = tag_of(op);
    chk({t, " acc_nxt"}, acc_nxt, na);
    chk({t, " cy_nxt"}, cy_nxt, nc);
    chk("R10 acc_we", acc_we, wa);
    chk("R10 cy_we", cy_we, wc);
    chk("R11 cost", cost, (ext && op <= 4'd7) ? 8 : 4);
    @(posedge clk);
    #1;
    if (v) begin
      if (wa) m_acc = na;
      if (wc) m_cy = nc;
    end
    chk(v ? {t, " acc_q"} : "R10 idle acc_q", acc_q, m_acc);
    chk(v ? {t, " cy_q"} : "R10 idle cy_q", cy_q, m_cy);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    rst = 1; op_valid = 0; op_sel = 0; operand = 0; opnd_ext = 0;
    repeat (2) @(posedge clk);
    #1;
    chk("R1 reset acc_q", acc_q, 0);
    chk("R1 reset cy_q", cy_q, 0);
    @(negedge clk);
    rst = 0;
    m_acc = 0; m_cy = 0;

    // directed corners
    step(1, 4'd0, 8'hFF, 0);  // R2: 0+FF no carry
    step(1, 4'd0, 8'h01, 1);  // R2: FF+1 -> 0, carry
    step(1, 4'd1, 8'hFF, 0);  // R3: 0+FF+1 -> 0, carry
    step(1, 4'd3, 8'h00, 0);  // R4: 0-0-1 -> FF, borrow
    step(1, 4'd2, 8'hFF, 1);  // R4: FF-FF -> 0
    step(1, 4'd10, 8'h00, 0); // R8: set carry
    step(1, 4'd5, 8'h5A, 0);  // R5: xor clears carry
    step(1, 4'd7, 8'h5B, 1);  // R6: 5A<5B
    step(1, 4'd7, 8'h5A, 1);  // R6: equal -> 0
    step(1, 4'd9, 8'h00, 0);  // R8: toggle
    step(1, 4'd8, 8'h00, 0);  // R7: complement keeps carry
    step(1, 4'd11, 8'h00, 0); // R9
    step(1, 4'd14, 8'h33, 1); // R10: reserved code
    step(0, 4'd0, 8'h77, 0);  // R10: not valid
    step(1, 4'd4, 8'h00, 0);  // R5: and -> 0
    step(1, 4'd12, 8'h00, 0); // R9: 0-1 wraps to FF
    step(1, 4'd11, 8'h00, 0); // R9: FF+1 wraps to 0

    for (int i = 0; i < 600; i++) begin
      step(($urandom % 8) != 0, 4'($urandom), 8'($urandom), 1'($urandom));
    end

    // reset in mid-run
    @(negedge clk);
    rst = 1; op_valid = 1; op_sel = 4'd10;
    @(posedge clk);
    #1;
    chk("R1 mid reset acc_q", acc_q, 0);
    chk("R1 mid reset cy_q", cy_q, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule